// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block shares one bus among six requesters that are split into two clusters of three. Each cluster runs its own four-slot round-robin rotation. Three of the slots belong to the cluster's own requesters. The fourth slot is a stand-in for the other cluster, so two small four-way rotations together serve all six requesters. Only one cluster owns arbitration at a time. When the owning cluster's rotation reaches its stand-in slot, ownership moves across. In that same arbitration step, the other cluster picks one of its own requesters.

A grant is issued only while the bus is idle. It is held until the holder pulses the bus-done strobe. The grant is presented in two forms: a one-hot six-bit vector, and a cluster bit with a 2-bit local slot number.

Top module: `dual_cluster_arbiter`

## Requirements
- R1: At most one bit of `gnt_o` is high in any cycle.
- R2: A grant is issued only in a cycle where the bus is idle (no grant held). A grant stays unchanged until `done_i` is sampled high. That edge clears it to zero. The next arbitration happens at the following edge.
- R3: Requester n of `req_i` belongs to cluster n/3, with local slot n%3. Cluster 0 is A and cluster 1 is B. When `gnt_o` bit n is high, `gnt_cl_o` equals n/3 and `gnt_id_o` equals n%3. While no grant is held, both read 0.
- R4: Within the owning cluster, the search starts at the slot after that cluster's last granted slot. Slots are tried in the order 0, 1, 2, 3 and wrap from 3 to 0.
- R5: Slot 3 of a cluster counts as requesting exactly when at least one requester of the other cluster is requesting.
- R6: When the owner's rotation selects slot 3, that slot becomes the owner's last granted slot and ownership passes to the other cluster. In the same step, the other cluster grants the first requesting local slot after its own last granted slot. A last value of 3 resumes at slot 0.
- R7: If the owning cluster has no local requests and the other cluster has some, a grant appears one cycle after the bus goes idle, with no empty cycles.
- R8: With no requests, no grant is issued, and ownership and both rotation positions keep their values.
- R9: A request held continuously is granted within six grants.
- R10: After reset, `gnt_o` is zero and cluster A owns arbitration. Both clusters start as if slot 3 was granted last, so the first search begins at slot 0. Reset assertion is asynchronous, and reset release is synchronised to the clock over two flops.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Request lines, bits 0-2 cluster A, bits 3-5 cluster B |
| done_i | input | 1 | Current bus holder has finished |
| gnt_o | output | 6 | One-hot grant |
| gnt_cl_o | output | 1 | Cluster of the granted requester (0 = A) |
| gnt_id_o | output | 2 | Local slot of the granted requester |

## Verification
The embedded assertions check four properties on every cycle:
- the grant is one-hot or zero;
- a grant is held stable while the bus is busy;
- a fresh grant appears only from an idle bus;
- a fresh grant goes to a requester that was asking, and an idle bus with no requests yields no grant.

Rotation order, the hand-over of ownership through the stand-in slot, resumption at the other cluster's own position and the six-grant bound depend on history. Only the bench can show these. It sweeps every nonzero request pattern and compares each grant against an arithmetic model of both rotations and the ownership bit.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic {CLU_A = 1'b0, CLU_B = 1'b1} clu_e;

  function automatic int flat_index(input logic cl, input int id, input int per_cluster);
    return (cl ? per_cluster : 0) + id;
  endfunction
endpackage

// File: rtl/dca_rr_pick.sv
module dca_rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] last_i,
  output logic          hit_o,
  output logic [PW-1:0] sel_o
);
  // Search begins one past the last granted slot; a last value outside
  // the slot range restarts the search at slot 0.
  always_comb begin
    int base;
    int c;
    base  = (int'(last_i) >= N - 1) ? 0 : int'(last_i) + 1;
    hit_o = 1'b0;
    sel_o = last_i;
    for (int k = 0; k < N; k++) begin
      c = base + k;
      if (c >= N) c = c - N;
      if (!hit_o && req_i[c]) begin
        hit_o = 1'b1;
        sel_o = PW'(c);
      end
    end
  end
endmodule

// File: rtl/dual_cluster_arbiter.sv
module dual_cluster_arbiter #(
  parameter int LOCAL_N = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_n_i,
  input  logic [2*LOCAL_N-1:0]              req_i,
  input  logic                              done_i,
  output logic [2*LOCAL_N-1:0]              gnt_o,
  output logic                              gnt_cl_o,
  output logic [$clog2(LOCAL_N+1)-1:0]      gnt_id_o
);
  import dca_pkg::*;

  localparam int SLOTS = LOCAL_N + 1;
  localparam int ID_W  = $clog2(SLOTS);
  localparam int REQ_N = 2 * LOCAL_N;
  localparam logic [ID_W-1:0] PH_ID = ID_W'(LOCAL_N);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // state
  logic                      own_q, own_d;
  logic [1:0][ID_W-1:0]      last_q, last_d;
  logic                      busy_q, busy_d;
  logic [REQ_N-1:0]          gnt_q, gnt_d;
  logic                      cl_q, cl_d;
  logic [ID_W-1:0]           id_q, id_d;
  logic                      upd_en;

  // per-cluster slot pickers
  logic [1:0][LOCAL_N-1:0]   loc_req;
  logic [1:0][SLOTS-1:0]     slot_req;
  logic [1:0]                hit_f, hit_l;
  logic [1:0][ID_W-1:0]      sel_f, sel_l;

  for (genvar g = 0; g < 2; g++) begin : g_clu
    assign loc_req[g]  = req_i[g*LOCAL_N +: LOCAL_N];
    assign slot_req[g] = {|req_i[(1-g)*LOCAL_N +: LOCAL_N], loc_req[g]};

    dca_rr_pick #(.N(SLOTS), .PW(ID_W)) u_full (
      .req_i (slot_req[g]),
      .last_i(last_q[g]),
      .hit_o (hit_f[g]),
      .sel_o (sel_f[g])
    );

    dca_rr_pick #(.N(LOCAL_N), .PW(ID_W)) u_local (
      .req_i (loc_req[g]),
      .last_i(last_q[g]),
      .hit_o (hit_l[g]),
      .sel_o (sel_l[g])
    );
  end

  // next state
  always_comb begin
    own_d  = own_q;
    last_d = last_q;
    busy_d = busy_q;
    gnt_d  = gnt_q;
    cl_d   = cl_q;
    id_d   = id_q;
    if (busy_q) begin
      if (done_i) begin
        busy_d = 1'b0;
        gnt_d  = '0;
        cl_d   = 1'b0;
        id_d   = '0;
      end
    end else if (hit_f[own_q]) begin
      if (sel_f[own_q] == PH_ID) begin
        own_d          = ~own_q;
        last_d[own_q]  = PH_ID;
        last_d[~own_q] = sel_l[~own_q];
        cl_d           = ~own_q;
        id_d           = sel_l[~own_q];
      end else begin
        last_d[own_q] = sel_f[own_q];
        cl_d          = own_q;
        id_d          = sel_f[own_q];
      end
      busy_d = 1'b1;
      gnt_d  = REQ_N'(1) << flat_index(cl_d, int'(id_d), LOCAL_N);
    end
  end

  assign upd_en = !busy_q || done_i;

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      own_q  <= CLU_A;
      last_q <= {PH_ID, PH_ID};
      busy_q <= 1'b0;
      gnt_q  <= '0;
      cl_q   <= 1'b0;
      id_q   <= '0;
    end else if (upd_en) begin
      own_q  <= own_d;
      last_q <= last_d;
      busy_q <= busy_d;
      gnt_q  <= gnt_d;
      cl_q   <= cl_d;
      id_q   <= id_d;
    end
  end

  assign gnt_o    = gnt_q;
  assign gnt_cl_o = cl_q;
  assign gnt_id_o = id_q;

  // assertions
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_s)
    $onehot0(gnt_o)); // R1

  AST_GNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_s)
    (gnt_o != '0 && !done_i) |=> $stable(gnt_o)); // R2

  AST_GNT_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_s)
    (gnt_o != '0 && gnt_o != $past(gnt_o)) |-> ($past(gnt_o) == '0)); // R2

  AST_GNT_WAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_s)
    (gnt_o != '0 && $past(gnt_o) == '0) |-> (($past(req_i) & gnt_o) != '0)); // R5

  AST_NO_REQ_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_s)
    (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0)); // R8
endmodule

// File: tb/dual_cluster_arbiter_test.sv
module dual_cluster_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 3;

  logic       clk;
  logic       rst_n;
  logic [5:0] req;
  logic       done;
  logic [5:0] gnt;
  logic       gcl;
  logic [1:0] gid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  int m_own;
  int m_last [2];
  int waitc [6];

  dual_cluster_arbiter #(.LOCAL_N(LN)) uut (
    .clk_i(clk), .rst_n_i(rst_n), .req_i(req), .done_i(done),
    .gnt_o(gnt), .gnt_cl_o(gcl), .gnt_id_o(gid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Next local slot of cluster c, after position p, among requesters only.
  function automatic int next_local(input logic [5:0] r, input int c, input int p);
    for (int k = 1; k <= LN + 1; k++) begin
      int s = (p + k) % (LN + 1);
      if (s < LN && r[c*LN + s]) return s;
    end
    return -1;
  endfunction

  // One arbitration step of the reference model; returns flat index or -1.
  task automatic model_step(input logic [5:0] r, output int idx, output int kind);
    int o, other, s;
    o = m_own; other = 1 - m_own;
    idx = -1; kind = 0;
    for (int k = 1; k <= LN + 1; k++) begin
      s = (m_last[o] + k) % (LN + 1);
      if (s < LN && r[o*LN + s]) begin
        m_last[o] = s; idx = o*LN + s; kind = 0;
        break;
      end
      if (s == LN && (r[other*LN +: LN] != 0)) begin
        m_last[o] = LN;
        s = next_local(r, other, m_last[other]);
        m_last[other] = s;
        m_own = other;
        idx = other*LN + s;
        kind = (r[o*LN +: LN] == 0) ? 2 : 1;
        break;
      end
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int exp_idx, kind, seen, prev;
    req = '0; done = 1'b0; rst_n = 1'b0;
    m_own = 0; m_last[0] = LN; m_last[1] = LN;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(gnt == 0, "R10 reset gnt", gnt, 0);
    check(gcl == 0 && gid == 0, "R10 reset cl/id", {gcl, gid}, 0);
    // R8 idle
    repeat (5) @(negedge clk);
    check(gnt == 0, "R8 idle no grant", gnt, 0);

    for (int p = 1; p < 64; p++) begin
      for (int i = 0; i < 6; i++) waitc[i] = 0;
      req = p[5:0];
      for (int g = 0; g < 8; g++) begin
        seen = 0;
        for (int w = 0; w < 3 && !seen; w++) begin
          @(negedge clk);
          if (gnt != 0) seen = 1;
        end
        model_step(p[5:0], exp_idx, kind);
        if (kind == 2)
          check(seen == 1 && gnt == (6'd1 << exp_idx), "R7 handover without idle", gnt, 1 << exp_idx);
        else if (kind == 1)
          check(gnt == (6'd1 << exp_idx), "R6 ownership via slot 3 (R5)", gnt, 1 << exp_idx);
        else
          check(gnt == (6'd1 << exp_idx), "R4 rotation order", gnt, 1 << exp_idx);
        check($countones(gnt) == 1, "R1 one-hot", $countones(gnt), 1);
        check(gcl == (exp_idx / LN) && gid == (exp_idx % LN), "R3 cluster/id",
              {gcl, gid}, ((exp_idx / LN) << 2) | (exp_idx % LN));
        for (int i = 0; i < 6; i++)
          if (p[i]) waitc[i] = (i == exp_idx) ? 0 : waitc[i] + 1;
        prev = 0;
        for (int i = 0; i < 6; i++) if (waitc[i] > prev) prev = waitc[i];
        check(prev <= 5, "R9 granted within six", prev, 5);
        // R2 hold while busy
        prev = gnt;
        repeat (2) @(negedge clk);
        check(gnt == prev[5:0], "R2 grant held", gnt, prev);
        done = 1'b1;
        @(negedge clk);
        check(gnt == 0 && gcl == 0 && gid == 0, "R2 done clears", gnt, 0);
        done = 1'b0;
        if (g == 7) req = '0;
      end
      // R8 idle gap keeps state (checked by the next pattern's model match)
      repeat (3) @(negedge clk);
      check(gnt == 0, "R8 no request no grant", gnt, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule